// File: doc/BRIEF.md
# USB Host IN Transaction Sequencer

This block carries out a single host-side IN transaction at packet level. Software first loads a 7-bit peripheral address into the address register. It then writes the transfer register with a zero upper nibble and the endpoint number in the low nibble. The block builds an IN token from the address, the endpoint and a computed CRC5, and hands it to the serializer as a one-cycle request. It then opens a bounded turnaround window and waits for the peripheral's reply.

The reply arrives as a decoded 4-bit PID with a status flag. The flag covers the packet's integrity checks, including CRC16, which is done outside this block. The block sorts the reply into one of six outcomes. It keeps one data-toggle bit per endpoint and decides whether an ACK handshake goes back. When the reply is good data whose PID matches the toggle, it flags the data as committed. Every transaction ends with a result code in a holding register and a one-cycle done pulse.

A data packet whose toggle does not match is still acknowledged. In that case the stored toggle is left alone and the data is not committed, so the peripheral's own toggle advances and the two sides come back into step.

Top module: `usb_in_xact`

## Requirements
- R1: A write to the transfer register (`cfg_sel`=1) whose bits [7:4] are 0000 starts a transaction on endpoint `cfg_wdata[3:0]`, and `tok_valid` pulses for exactly one cycle, two clock edges after the write edge. A write to the transfer register with a nonzero upper nibble starts nothing.
- R2: While `tok_valid` is high, `tok_pid` is 8'h69 (IN PID 4'b1001 in the low nibble, its complement in the high nibble). `tok_addr` holds the last value written to the address register (`cfg_sel`=0, bits [6:0]), and `tok_ep` holds the endpoint.
- R3: `tok_crc5` is computed over the 11 bits {endpoint, address}, processed from bit 0 of the address upward. The polynomial is x^5+x^2+1 (feedback mask 5'b00101, shifting toward bit 4), the register starts at 5'b11111, and the output is the bitwise complement of the final register.
- R4: A reply is accepted if `rx_valid` is high in any of the first WIN = 13*HALF_BIT_CYC cycles, counting the cycle in which `tok_valid` is high as the first. With no reply in that window, the transaction ends WIN edges after `tok_valid` rose, with result 4'b1110 and no ACK.
- R5: DATA0 (4'b0011) or DATA1 (4'b1011) without `rx_err`, whose PID bit 3 equals the endpoint's toggle, produces the following: `hs_ack` and `data_avail` pulse, the result is 4'b0000, and that endpoint's toggle inverts. Each endpoint has its own toggle, and all toggles start at 0.
- R6: A data PID without `rx_err` whose bit 3 differs from the endpoint's toggle gets `hs_ack`, with no `data_avail` and no toggle change. The result is 4'b0110.
- R7: A data PID with `rx_err` set gets no ACK and no `data_avail`, and leaves the toggle unchanged. The result is 4'b0011.
- R8: NAK (4'b1010) ends with result 4'b0100 and STALL (4'b1110) ends with result 4'b0101. Neither gets an ACK, commits data or changes a toggle.
- R9: Any other reply PID, or a handshake PID with `rx_err` set, ends with result 4'b0011 and no ACK.
- R10: Every transaction ends with a single one-cycle `xfer_done` pulse, in the same cycle as `hs_ack` and `data_avail`. `result` changes only at that point.
- R11: `busy` is high from the start write until the end of the transaction. Transfer writes made while busy, and replies arriving outside the turnaround window, have no effect.
- R12: After reset, `result` is 4'b0000, and `busy`, `tok_valid`, `hs_ack`, `data_avail` and `xfer_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the address register, 1 selects the transfer register |
| cfg_wdata | input | 8 | Write data |
| tok_valid | output | 1 | One-cycle token request to the serializer |
| tok_pid | output | 8 | Token PID byte |
| tok_addr | output | 7 | Token address field |
| tok_ep | output | 4 | Token endpoint field |
| tok_crc5 | output | 5 | Token CRC5 |
| rx_valid | input | 1 | Reply PID is present this cycle |
| rx_pid | input | 4 | Decoded reply PID (low nibble) |
| rx_err | input | 1 | Reply failed an integrity check |
| hs_ack | output | 1 | Send an ACK handshake |
| data_avail | output | 1 | Received data committed |
| xfer_done | output | 1 | Transaction finished pulse |
| result | output | 4 | Result code of the last transaction |
| busy | output | 1 | Transaction in progress |

## Verification
The token path is swept over every address and endpoint pair, with a NAK reply each time. This separates CRC5 bit-ordering and initial-value faults from field-routing faults. On one endpoint, a scripted sequence of DATA0 and DATA1 replies, some with errors, tells a correct toggle from one that advances on mismatches or on damaged data. A second endpoint shows the toggles are separate per endpoint. The reply delay is swept across the whole window and one cycle past it, which pins down off-by-one errors in the timeout. STALL, stray PIDs, idle replies and writes made while busy cover the remaining classification and ignore paths.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;
  localparam int ADDR_W = 7;

  localparam logic [3:0] PID_IN    = 4'b1001;
  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;
  localparam logic [3:0] PID_NAK   = 4'b1010;
  localparam logic [3:0] PID_STALL = 4'b1110;

  typedef enum logic [3:0] {
    RES_OK      = 4'b0000,
    RES_BADPKT  = 4'b0011,
    RES_NAK     = 4'b0100,
    RES_STALL   = 4'b0101,
    RES_TOGERR  = 4'b0110,
    RES_TIMEOUT = 4'b1110
  } res_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TOKEN = 2'd1,
    ST_WAIT  = 2'd2
  } st_t;
endpackage

// File: rtl/usb_crc5.sv
module usb_crc5 #(
  parameter int DATA_W = 11
) (
  input  logic [DATA_W-1:0] din,
  output logic [4:0]        crc
);
  logic [4:0] lfsr;
  logic       fb;

  always_comb begin
    lfsr = 5'h1F;
    fb   = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      fb   = din[i] ^ lfsr[4];
      lfsr = {lfsr[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
    end
    crc = ~lfsr;
  end
endmodule

// File: rtl/usb_toggle_bank.sv
module usb_toggle_bank #(
  parameter int EP_W   = 4,
  parameter int NUM_EP = 1 << EP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EP_W-1:0] ep_sel,
  input  logic            flip,
  output logic            cur
);
  logic [NUM_EP-1:0] tog_q;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    always_ff @(posedge clk) begin
      if (rst)
        tog_q[i] <= 1'b0;
      else if (flip && (ep_sel == EP_W'(i)))
        tog_q[i] <= ~tog_q[i];
    end
  end

  assign cur = tog_q[ep_sel];
endmodule

// File: rtl/usb_ta_timer.sv
module usb_ta_timer #(
  parameter int WIN = 26
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (en)
      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == CW'(WIN - 1));
endmodule

// File: rtl/usb_in_xact.sv
module usb_in_xact
  import usb_in_pkg::*;
#(
  parameter int HALF_BIT_CYC = 2,
  parameter int EP_W         = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic                 cfg_sel,
  input  logic [7:0]           cfg_wdata,
  output logic                 tok_valid,
  output logic [7:0]           tok_pid,
  output logic [ADDR_W-1:0]    tok_addr,
  output logic [EP_W-1:0]      tok_ep,
  output logic [4:0]           tok_crc5,
  input  logic                 rx_valid,
  input  logic [3:0]           rx_pid,
  input  logic                 rx_err,
  output logic                 hs_ack,
  output logic                 data_avail,
  output logic                 xfer_done,
  output logic [3:0]           result,
  output logic                 busy
);
  localparam int WIN    = 13 * HALF_BIT_CYC;
  localparam int NUM_EP = 1 << EP_W;

  st_t                 state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [EP_W-1:0]     ep_q;
  logic [4:0]          crc_w;
  logic                tog_cur;
  logic                expired;
  logic                start;
  logic                rx_take;

  res_t                cls_res;
  logic                cls_ack;
  logic                cls_commit;

  logic                tok_valid_q, hs_ack_q, data_avail_q, done_q, busy_q;
  logic [ADDR_W-1:0]   tok_addr_q;
  logic [EP_W-1:0]     tok_ep_q;
  logic [4:0]          tok_crc_q;
  res_t                result_q;

  assign start   = cfg_wr && cfg_sel && (cfg_wdata[7:EP_W] == '0) && (state_q == ST_IDLE);
  assign rx_take = rx_valid && (state_q == ST_WAIT);

  usb_crc5 #(.DATA_W(ADDR_W + EP_W)) u_crc (
    .din ({ep_q, addr_q}),
    .crc (crc_w)
  );

  usb_toggle_bank #(.EP_W(EP_W), .NUM_EP(NUM_EP)) u_tog (
    .clk    (clk),
    .rst    (rst),
    .ep_sel (ep_q),
    .flip   (rx_take && cls_commit),
    .cur    (tog_cur)
  );

  usb_ta_timer #(.WIN(WIN)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (state_q == ST_TOKEN),
    .en      (state_q == ST_WAIT),
    .expired (expired)
  );

  // Reply classification
  always_comb begin
    cls_res    = RES_BADPKT;
    cls_ack    = 1'b0;
    cls_commit = 1'b0;
    if (rx_pid == PID_DATA0 || rx_pid == PID_DATA1) begin
      if (rx_err) begin
        cls_res = RES_BADPKT;
      end else if (rx_pid[3] == tog_cur) begin
        cls_res    = RES_OK;
        cls_ack    = 1'b1;
        cls_commit = 1'b1;
      end else begin
        cls_res = RES_TOGERR;
        cls_ack = 1'b1;
      end
    end else if (rx_err) begin
      cls_res = RES_BADPKT;
    end else if (rx_pid == PID_NAK) begin
      cls_res = RES_NAK;
    end else if (rx_pid == PID_STALL) begin
      cls_res = RES_STALL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      ep_q         <= '0;
      tok_valid_q  <= 1'b0;
      tok_addr_q   <= '0;
      tok_ep_q     <= '0;
      tok_crc_q    <= '0;
      hs_ack_q     <= 1'b0;
      data_avail_q <= 1'b0;
      done_q       <= 1'b0;
      busy_q       <= 1'b0;
      result_q     <= RES_OK;
    end else begin
      tok_valid_q  <= 1'b0;
      hs_ack_q     <= 1'b0;
      data_avail_q <= 1'b0;
      done_q       <= 1'b0;
      if (cfg_wr && !cfg_sel)
        addr_q <= cfg_wdata[ADDR_W-1:0];
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            ep_q    <= cfg_wdata[EP_W-1:0];
            busy_q  <= 1'b1;
            state_q <= ST_TOKEN;
          end
        end
        ST_TOKEN: begin
          tok_valid_q <= 1'b1;
          tok_addr_q  <= addr_q;
          tok_ep_q    <= ep_q;
          tok_crc_q   <= crc_w;
          state_q     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rx_valid) begin
            result_q     <= cls_res;
            hs_ack_q     <= cls_ack;
            data_avail_q <= cls_commit;
            done_q       <= 1'b1;
            busy_q       <= 1'b0;
            state_q      <= ST_IDLE;
          end else if (expired) begin
            result_q <= RES_TIMEOUT;
            done_q   <= 1'b1;
            busy_q   <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tok_valid  = tok_valid_q;
  assign tok_pid    = {~PID_IN, PID_IN};
  assign tok_addr   = tok_addr_q;
  assign tok_ep     = tok_ep_q;
  assign tok_crc5   = tok_crc_q;
  assign hs_ack     = hs_ack_q;
  assign data_avail = data_avail_q;
  assign xfer_done  = done_q;
  assign result     = result_q;
  assign busy       = busy_q;
endmodule

// File: rtl/usb_in_xact_checker.sv
module usb_in_xact_checker #(
  parameter int WIN = 26
) (
  input logic       clk,
  input logic       rst,
  input logic       tok_valid,
  input logic       hs_ack,
  input logic       data_avail,
  input logic       xfer_done,
  input logic [3:0] result,
  input logic       busy
);
  logic [15:0] since_tok;

  always_ff @(posedge clk) begin
    if (rst)
      since_tok <= 16'd0;
    else if (tok_valid)
      since_tok <= 16'd1;
    else if (since_tok != 16'hFFFF)
      since_tok <= since_tok + 16'd1;
  end

  assert_tok_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    tok_valid |=> !tok_valid);

  assert_tok_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
    tok_valid |-> busy);

  assert_timeout_window_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && result == 4'b1110) |-> since_tok == 16'(WIN));

  assert_done_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (since_tok <= 16'(WIN) && since_tok != 16'd0));

  assert_commit_ok_R5: assert property (@(posedge clk) disable iff (rst)
    data_avail |-> (xfer_done && hs_ack && result == 4'b0000));

  assert_ack_codes_R6: assert property (@(posedge clk) disable iff (rst)
    hs_ack |-> (xfer_done && (result == 4'b0000 || result == 4'b0110)));

  assert_no_ack_bad_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && result == 4'b0011) |-> (!hs_ack && !data_avail));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !xfer_done |-> $stable(result));
endmodule

bind usb_in_xact usb_in_xact_checker #(.WIN(13 * HALF_BIT_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tok_valid  (tok_valid),
  .hs_ack     (hs_ack),
  .data_avail (data_avail),
  .xfer_done  (xfer_done),
  .result     (result),
  .busy       (busy)
);

// File: tb/usb_in_xact_test.sv
module usb_in_xact_test;
  localparam int HB  = 2;
  localparam int WIN = 13 * HB;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       tok_valid;
  logic [7:0] tok_pid;
  logic [6:0] tok_addr;
  logic [3:0] tok_ep;
  logic [4:0] tok_crc5;
  logic       rx_valid = 1'b0;
  logic [3:0] rx_pid = 4'h0;
  logic       rx_err = 1'b0;
  logic       hs_ack, data_avail, xfer_done, busy;
  logic [3:0] result;

  int checks = 0;
  int errors = 0;
  bit tgl [16];

  always #2 clk = ~clk;

  usb_in_xact #(.HALF_BIT_CYC(HB), .EP_W(4)) uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .tok_crc5(tok_crc5), .rx_valid(rx_valid), .rx_pid(rx_pid), .rx_err(rx_err),
    .hs_ack(hs_ack), .data_avail(data_avail), .xfer_done(xfer_done),
    .result(result), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_crc(input logic [6:0] a, input logic [3:0] e);
    logic [10:0] bits;
    logic [4:0]  r;
    logic        t;
    bits = {e, a};
    r = 5'b11111;
    for (int i = 0; i < 11; i++) begin
      t = bits[i] ^ r[4];
      r = {r[3:0], 1'b0};
      if (t) r = r ^ 5'b00101;
    end
    return ~r;
  endfunction

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Starts a transaction; returns at the negedge in which tok_valid should be high.
  task automatic launch(input logic [6:0] a, input logic [3:0] e, input bit full);
    wr(1'b0, {1'b0, a});
    wr(1'b1, {4'h0, e});
    if (full) begin
      chk("R11 busy after start", busy, 1);
      chk("R1 token not yet", tok_valid, 0);
    end
    @(negedge clk);
    chk("R1 token pulse", tok_valid, 1);
    if (full) chk("R2 pid", tok_pid, 8'h69);
    chk("R2 addr", tok_addr, a);
    chk("R2 ep", tok_ep, e);
    chk("R3 crc5", tok_crc5, ref_crc(a, e));
  endtask

  task automatic reply(input logic [3:0] e, input int d, input logic [3:0] p, input bit er);
    int  xr;
    bit  xa, xd;
    bit  is_data;
    repeat (d) @(negedge clk);
    rx_valid = 1'b1; rx_pid = p; rx_err = er;
    @(negedge clk);
    rx_valid = 1'b0;
    is_data = (p == 4'b0011 || p == 4'b1011);
    xa = 0; xd = 0;
    if (is_data && er)                 xr = 4'b0011;
    else if (is_data && p[3] == tgl[e]) begin xr = 4'b0000; xa = 1; xd = 1; tgl[e] = ~tgl[e]; end
    else if (is_data)                  begin xr = 4'b0110; xa = 1; end
    else if (er)                       xr = 4'b0011;
    else if (p == 4'b1010)             xr = 4'b0100;
    else if (p == 4'b1110)             xr = 4'b0101;
    else                               xr = 4'b0011;
    chk("R10 done pulse", xfer_done, 1);
    chk("R5 R6 R7 R8 R9 result", result, xr);
    chk("R5 R6 R7 ack", hs_ack, xa);
    chk("R5 R6 R7 data_avail", data_avail, xd);
    @(negedge clk);
    chk("R10 done one cycle", xfer_done, 0);
    chk("R11 busy cleared", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    for (int i = 0; i < 16; i++) tgl[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 result", result, 0);
    chk("R12 busy", busy, 0);
    chk("R12 tok_valid", tok_valid, 0);
    chk("R12 hs_ack", hs_ack, 0);
    chk("R12 data_avail", data_avail, 0);
    chk("R12 xfer_done", xfer_done, 0);

    // R2 R3 R8: sweep every address/endpoint pair with NAK replies
    for (int a = 0; a < 128; a++)
      for (int e = 0; e < 16; e++) begin
        launch(7'(a), 4'(e), (a == 0));
        reply(4'(e), 0, 4'b1010, 1'b0);
      end

    // R5 R6 R7 toggle sequence on endpoint 5
    launch(7'h11, 4'd5, 1'b1); reply(4'd5, 1, 4'b0011, 1'b0); // R5 DATA0 ok
    launch(7'h11, 4'd5, 1'b1); reply(4'd5, 2, 4'b0011, 1'b0); // R6 mismatch
    launch(7'h11, 4'd5, 1'b1); reply(4'd5, 0, 4'b1011, 1'b0); // R5 DATA1 ok
    launch(7'h11, 4'd5, 1'b1); reply(4'd5, 3, 4'b1011, 1'b1); // R7 error, no flip
    launch(7'h11, 4'd5, 1'b1); reply(4'd5, 0, 4'b0011, 1'b0); // R7 toggle still 0
    launch(7'h11, 4'd5, 1'b1); reply(4'd5, 0, 4'b0011, 1'b1); // R7 error data
    launch(7'h11, 4'd5, 1'b1); reply(4'd5, 0, 4'b1011, 1'b0); // R5 toggle now 1
    // R5 independent toggle on endpoint 9
    launch(7'h22, 4'd9, 1'b1); reply(4'd9, 0, 4'b0011, 1'b0);
    launch(7'h22, 4'd9, 1'b1); reply(4'd9, 0, 4'b1011, 1'b0);
    // R8 STALL, R9 other PIDs and handshake with error
    launch(7'h33, 4'd2, 1'b1); reply(4'd2, 0, 4'b1110, 1'b0);
    launch(7'h33, 4'd2, 1'b1); reply(4'd2, 0, 4'b0010, 1'b0);
    launch(7'h33, 4'd2, 1'b1); reply(4'd2, 0, 4'b1010, 1'b1);
    launch(7'h33, 4'd2, 1'b1); reply(4'd2, 0, 4'b0111, 1'b0);

    // R10 result holds between transactions
    repeat (5) @(negedge clk);
    chk("R10 result held", result, 4'b0011);
    chk("R10 no stray done", xfer_done, 0);

    // R4 window sweep: every delay inside the window is accepted
    for (int d = 0; d < WIN; d++) begin
      launch(7'h44, 4'd7, 1'b0);
      reply(4'd7, d, 4'b1110, 1'b0);
    end

    // R4 timeout, with a late reply one cycle past the window ignored
    launch(7'h55, 4'd3, 1'b1);
    n = 0;
    while (!xfer_done && n < WIN + 4) begin
      @(negedge clk);
      n++;
    end
    chk("R4 timeout cycle", n, WIN);
    chk("R4 timeout result", result, 4'b1110);
    chk("R4 timeout no ack", hs_ack, 0);
    rx_valid = 1'b1; rx_pid = 4'b0011; rx_err = 1'b0;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R11 late reply ignored", xfer_done, 0);
    chk("R11 late reply no ack", hs_ack, 0);
    chk("R4 result after late reply", result, 4'b1110);
    launch(7'h55, 4'd3, 1'b1); reply(4'd3, 0, 4'b0011, 1'b0); // toggle of ep3 untouched

    // R1 nonzero upper nibble starts nothing
    wr(1'b1, 8'h13);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      if (tok_valid || busy) seen = 1;
      @(negedge clk);
    end
    chk("R1 nonzero nibble ignored", seen, 0);

    // R11 idle reply ignored
    rx_valid = 1'b1; rx_pid = 4'b0011; rx_err = 1'b0;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R11 idle reply done", xfer_done, 0);
    chk("R11 idle reply ack", hs_ack, 0);
    chk("R11 idle reply data", data_avail, 0);
    launch(7'h66, 4'd4, 1'b1); reply(4'd4, 0, 4'b0011, 1'b0); // toggle of ep4 still 0

    // R11 start write while busy ignored
    launch(7'h66, 4'd2, 1'b1);
    cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h03;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R11 busy kept", busy, 1);
    reply(4'd2, 0, 4'b1010, 1'b0);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      if (tok_valid || busy) seen = 1;
      @(negedge clk);
    end
    chk("R11 write while busy ignored", seen, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule